// File: doc/BRIEF.md
# Microstepping Step/Direction Indexer

This block drives a two-phase bipolar stepper from a step-pulse stream and a direction level. It keeps a 7-bit electrical phase position (128 positions per electrical turn, 2.8125° each). For each winding it produces a sign bit and a 5-bit magnitude code for a downstream current DAC. Winding A follows the cosine of the phase and winding B follows the sine. The step resolution runs from full step to 1/32 step and can be changed while the motor runs. After a change the position moves to the next position that is valid for the new resolution, in the direction of travel.

All control inputs are synchronized to the clock, and the step input is also deglitched. A per-winding rising flag marks a step that increased that winding's magnitude. On such a step the block forces the winding's decay request to slow decay; otherwise the externally chosen decay code passes straight through. `sleep_i` acts as a synchronous reset for sleep or undervoltage: it returns the indexer to the 45° home position and turns the drive off.

Top module: `stepper_indexer`

## Requirements
- R1: After `rst_ni` is released, the position is 45° (phase index 16). At that position both magnitudes are 22, both sign bits are 0 and both rising flags are 0.
- R2: Each deglitched rising edge of `step_i` moves the phase index by one increment of the current resolution. `dir_i`=1 moves it forward, `dir_i`=0 moves it backward, and the index wraps modulo 128. Without such an edge the index holds.
- R3: The resolution is decoded from `m1_i` and `m0_i`, where `m0_i` is 00=low, 01=high, 1x=open. {m1,m0} low/low gives full step, low/high half step, low/open quarter step, high/low eighth step, high/high sixteenth step and high/open thirty-second step. Resolution k (full=0 … thirty-second=5) uses an increment of 2^(5-k) index units. `m1_i`, `m0_i` and `dir_i` are sampled at the step edge.
- R4: In full-step mode the index only takes the values 16, 48, 80 and 112 (45°, 135°, 225°, 315°).
- R5: After a change of resolution, the next step goes to the nearest index in the direction of travel that is valid for the new resolution. For the finer modes a valid index is a multiple of the increment.
- R6: With θ = index·2.8125°, `b_mag_o` = round(31·|sin θ|) and `a_mag_o` = round(31·|cos θ|).
- R7: A sign bit of 1 means negative current, which is output 2 positive with respect to output 1. `b_sign_o` is 1 for indices 64..127. `a_sign_o` is 1 for indices 32..95.
- R8: `drive_en_o` is 0 while the synchronized `out_dis_i` is 1 or `sleep_i` is 1. Steps taken while the output is disabled still move the position.
- R9: A winding's rising flag is 1 when its magnitude after the latest step is greater than before that step. While the flag is set, that winding's decay output is 0 (slow decay). Otherwise the decay output equals `decay_sel_i`.
- R10: A `step_i` pulse shorter than DEGLITCH clock cycles, after synchronization, does not move the position.
- R11: While `sleep_i` is 1, steps are ignored, the outputs show the home position and the rising flags are 0. Release from sleep resumes operation from the home position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Synchronous reset for sleep or undervoltage |
| step_i | input | 1 | Step pulse, rising edge advances |
| dir_i | input | 1 | Direction, 1 = forward |
| m1_i | input | 1 | Resolution select, high bit |
| m0_i | input | 2 | Resolution select, tri-level low bit (00 low, 01 high, 1x open) |
| out_dis_i | input | 1 | Output disable, active high |
| decay_sel_i | input | 3 | Externally selected decay code, 0 = slow |
| drive_en_o | output | 1 | Power stage enable |
| a_sign_o | output | 1 | Winding A sign, 1 = negative |
| a_mag_o | output | 5 | Winding A magnitude code |
| a_rise_o | output | 1 | Winding A magnitude rose on last step |
| a_decay_o | output | 3 | Winding A decay request |
| b_sign_o | output | 1 | Winding B sign, 1 = negative |
| b_mag_o | output | 5 | Winding B magnitude code |
| b_rise_o | output | 1 | Winding B magnitude rose on last step |
| b_decay_o | output | 3 | Winding B decay request |

## Verification
Some properties are checked on every cycle by assertions:
- the index holds between steps and moves on each step;
- full-step mode stays on the odd 45° positions;
- the index stays aligned to the latched resolution;
- the two magnitudes stay in quadrature (sum of squares near 31²);
- the rising flag changes only right after a step;
- the deglitched edge is a single-cycle pulse;
- sleep drops the drive enable.

Other behaviour is shown only by the bench scenarios, against a model that finds target positions by search and magnitudes by trigonometry:
- the exact magnitude and sign values;
- snapping to the next valid position after a mode change;
- rejection of short glitches;
- stepping that continues while the output is disabled;
- the return to home after sleep.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int QW_LOG2  = 5;
  localparam int IDX_W    = QW_LOG2 + 2;
  localparam int MAG_W    = 5;
  localparam int DECAY_W  = 3;
  localparam int HOME_IDX = 1 << (QW_LOG2 - 1);
  localparam int QTR      = 1 << QW_LOG2;

  typedef enum logic [2:0] {
    RES_FULL = 3'd0, RES_HALF = 3'd1, RES_QUARTER = 3'd2,
    RES_EIGHTH = 3'd3, RES_SIXTEENTH = 3'd4, RES_32ND = 3'd5
  } res_e;

  // m0 tri-level: 00 low, 01 high, 1x open
  function automatic res_e decode_res(logic m1, logic [1:0] m0);
    logic [2:0] lo;
    lo = m0[1] ? 3'd2 : (m0[0] ? 3'd1 : 3'd0);
    return res_e'(m1 ? 3'd3 + lo : lo);
  endfunction

  // round(31*sin(i*90/32 deg)), i = 0..32
  function automatic logic [MAG_W-1:0] quarter_mag(logic [QW_LOG2:0] i);
    case (i)
      6'd0: return 5'd0;    6'd1: return 5'd2;    6'd2: return 5'd3;
      6'd3: return 5'd5;    6'd4: return 5'd6;    6'd5: return 5'd8;
      6'd6: return 5'd9;    6'd7: return 5'd10;   6'd8: return 5'd12;
      6'd9: return 5'd13;   6'd10: return 5'd15;  6'd11: return 5'd16;
      6'd12: return 5'd17;  6'd13: return 5'd18;  6'd14: return 5'd20;
      6'd15: return 5'd21;  6'd16: return 5'd22;  6'd17: return 5'd23;
      6'd18: return 5'd24;  6'd19: return 5'd25;  6'd20: return 5'd26;
      6'd21: return 5'd27;  6'd22: return 5'd27;  6'd23: return 5'd28;
      6'd24: return 5'd29;  6'd25: return 5'd29;  6'd26: return 5'd30;
      6'd27: return 5'd30;  6'd28: return 5'd30;  6'd29: return 5'd31;
      6'd30: return 5'd31;  6'd31: return 5'd31;  6'd32: return 5'd31;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/stp_in_sync.sv
module stp_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/stp_deglitch.sv
module stp_deglitch #(
  parameter int DG = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  output logic rise_o
);
  localparam int CNT_W = (DG > 2) ? $clog2(DG) : 1;

  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lvl_i != filt_q) begin
      if (cnt_q == CNT_W'(DG - 1)) begin
        filt_q <= lvl_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign rise_o = lvl_i && !filt_q && (cnt_q == CNT_W'(DG - 1)) && !clr_i;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R10
endmodule

// File: rtl/stp_phase_ctr.sv
module stp_phase_ctr
  import stp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             dir_i,
  input  res_e             res_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d, step_sz, ofs, rel, base, rel_n;
  res_e             res_q;

  always_comb begin
    step_sz = IDX_W'(1) << (QW_LOG2 - int'(res_i));
    ofs     = (res_i == RES_FULL) ? IDX_W'(HOME_IDX) : '0;
    rel     = idx_q - ofs;
    base    = rel & ~(step_sz - IDX_W'(1));
    if (dir_i)             rel_n = base + step_sz;
    else if (rel != base)  rel_n = base;
    else                   rel_n = rel - step_sz;
    idx_d = rel_n + ofs;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_W'(HOME_IDX);
      res_q <= RES_FULL;
    end else if (clr_i) begin
      idx_q <= IDX_W'(HOME_IDX);
      res_q <= RES_FULL;
    end else if (adv_i) begin
      idx_q <= idx_d;
      res_q <= res_i;
    end
  end

  assign idx_o = idx_q;

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(idx_q)); // R2
  AST_IDX_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (idx_q != $past(idx_q))); // R2
  AST_FULL_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q == RES_FULL) |-> (idx_q[QW_LOG2-1:0] == 5'(HOME_IDX))); // R4
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q != RES_FULL) |->
      ((idx_q & ((IDX_W'(1) << (QW_LOG2 - int'(res_q))) - IDX_W'(1))) == '0)); // R5
endmodule

// File: rtl/stp_wave_lut.sv
module stp_wave_lut
  import stp_pkg::*;
#(
  parameter int PHASE_OFS = 0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [IDX_W-1:0]   ph;
  logic [QW_LOG2:0]   qi;
  logic [QW_LOG2-1:0] r;

  always_comb begin
    ph = idx_i + IDX_W'(PHASE_OFS);
    r  = ph[QW_LOG2-1:0];
    qi = ph[QW_LOG2] ? ((QW_LOG2+1)'(QTR) - {1'b0, r}) : {1'b0, r};
    mag_o  = quarter_mag(qi);
    sign_o = ph[IDX_W-1];
  end
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stp_pkg::*;
#(
  parameter int DEGLITCH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic               step_i,
  input  logic               dir_i,
  input  logic               m1_i,
  input  logic [1:0]         m0_i,
  input  logic               out_dis_i,
  input  logic [DECAY_W-1:0] decay_sel_i,
  output logic               drive_en_o,
  output logic               a_sign_o,
  output logic [MAG_W-1:0]   a_mag_o,
  output logic               a_rise_o,
  output logic [DECAY_W-1:0] a_decay_o,
  output logic               b_sign_o,
  output logic [MAG_W-1:0]   b_mag_o,
  output logic               b_rise_o,
  output logic [DECAY_W-1:0] b_decay_o
);
  localparam int NW   = 2;
  localparam int IN_W = 6;

  logic [IN_W-1:0]  raw, syn;
  logic             step_s, dir_s, m1_s, dis_s;
  logic [1:0]       m0_s;
  logic             adv, adv_d_q, en_q;
  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag   [NW];
  logic             sgn   [NW];
  logic [MAG_W-1:0] prev_q[NW];
  logic             rise_q[NW];
  logic [DECAY_W-1:0] dec [NW];

  assign raw = {out_dis_i, m1_i, m0_i, dir_i, step_i};
  assign {dis_s, m1_s, m0_s, dir_s, step_s} = syn;

  stp_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(raw), .sync_o(syn)
  );

  stp_deglitch #(.DG(DEGLITCH)) u_dg (
    .clk_i, .rst_ni, .clr_i(sleep_i), .lvl_i(step_s), .rise_o(adv)
  );

  stp_phase_ctr u_ctr (
    .clk_i, .rst_ni, .clr_i(sleep_i), .adv_i(adv), .dir_i(dir_s),
    .res_i(decode_res(m1_s, m0_s)), .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_d_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      adv_d_q <= adv && !sleep_i;
      en_q    <= !dis_s && !sleep_i;
    end
  end

  // winding 0 = A (cosine), winding 1 = B (sine)
  for (genvar w = 0; w < NW; w++) begin : g_wind
    stp_wave_lut #(.PHASE_OFS(w == 0 ? QTR : 0)) u_lut (
      .idx_i(idx), .sign_o(sgn[w]), .mag_o(mag[w])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[w] <= MAG_W'(22);
        rise_q[w] <= 1'b0;
      end else if (sleep_i) begin
        prev_q[w] <= MAG_W'(22);
        rise_q[w] <= 1'b0;
      end else begin
        if (adv) prev_q[w] <= mag[w];
        if (adv_d_q) rise_q[w] <= (mag[w] > prev_q[w]);
      end
    end

    assign dec[w] = rise_q[w] ? '0 : decay_sel_i;

    AST_RISE_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!adv_d_q && !sleep_i) |=> $stable(rise_q[w])); // R9
  end

  assign drive_en_o = en_q;
  assign a_sign_o   = sgn[0];
  assign a_mag_o    = mag[0];
  assign a_rise_o   = rise_q[0];
  assign a_decay_o  = dec[0];
  assign b_sign_o   = sgn[1];
  assign b_mag_o    = mag[1];
  assign b_rise_o   = rise_q[1];
  assign b_decay_o  = dec[1];

  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !drive_en_o); // R8
  AST_QUADRATURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((11'(a_mag_o) * 11'(a_mag_o) + 11'(b_mag_o) * 11'(b_mag_o)) >= 11'd900) &&
    ((11'(a_mag_o) * 11'(a_mag_o) + 11'(b_mag_o) * 11'(b_mag_o)) <= 11'd1000)); // R6
endmodule

// File: tb/stepper_indexer_bench.sv
module stepper_indexer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0;
  logic       step_i = 1'b0;
  logic       dir_i = 1'b1;
  logic       m1_i = 1'b0;
  logic [1:0] m0_i = 2'b00;
  logic       out_dis_i = 1'b0;
  logic [2:0] decay_sel_i = 3'd3;
  logic       drive_en_o, a_sign_o, a_rise_o, b_sign_o, b_rise_o;
  logic [4:0] a_mag_o, b_mag_o;
  logic [2:0] a_decay_o, b_decay_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int pos    = 16;
  int res    = 0;
  int exp_ra = 0;
  int exp_rb = 0;

  always #10 clk_i = ~clk_i;

  stepper_indexer u_stepper_indexer (
    .clk_i, .rst_ni, .sleep_i, .step_i, .dir_i, .m1_i, .m0_i, .out_dis_i,
    .decay_sel_i, .drive_en_o, .a_sign_o, .a_mag_o, .a_rise_o, .a_decay_o,
    .b_sign_o, .b_mag_o, .b_rise_o, .b_decay_o
  );

  function automatic int exp_mag(int p, bit cosine);
    real th, v;
    th = 2.0 * 3.14159265358979 * p / 128.0;
    v  = cosine ? $cos(th) : $sin(th);
    if (v < 0.0) v = -v;
    return $rtoi(31.0 * v + 0.5);
  endfunction

  function automatic int next_pos(int p, int k, bit fwd);
    int s = 32 >> k;
    for (int d = 1; d <= 128; d++) begin
      int c = fwd ? (p + d) % 128 : (p - d + 128) % 128;
      if (k == 0 ? (c % 32 == 16) : (c % s == 0)) return c;
    end
    return p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s pos=%0d actual %0d expected %0d", req, pos, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " a_mag R6"}, a_mag_o, exp_mag(pos, 1));
    chk({req, " b_mag R6"}, b_mag_o, exp_mag(pos, 0));
    chk({req, " a_sign R7"}, a_sign_o, (pos >= 32 && pos < 96) ? 1 : 0);
    chk({req, " b_sign R7"}, b_sign_o, (pos >= 64) ? 1 : 0);
    chk({req, " a_rise R9"}, a_rise_o, exp_ra);
    chk({req, " b_rise R9"}, b_rise_o, exp_rb);
    chk({req, " a_decay R9"}, a_decay_o, exp_ra ? 0 : int'(decay_sel_i));
    chk({req, " b_decay R9"}, b_decay_o, exp_rb ? 0 : int'(decay_sel_i));
  endtask

  task automatic set_res(int k);
    @(negedge clk_i);
    m1_i = (k >= 3);
    m0_i = (k % 3 == 0) ? 2'b00 : ((k % 3 == 1) ? 2'b01 : 2'b10);
    res  = k;
  endtask

  task automatic do_step(bit fwd, string req);
    int pa, pb;
    @(negedge clk_i);
    dir_i = fwd;
    pa = exp_mag(pos, 1);
    pb = exp_mag(pos, 0);
    pos = next_pos(pos, res, fwd);
    exp_ra = (exp_mag(pos, 1) > pa) ? 1 : 0;
    exp_rb = (exp_mag(pos, 0) > pb) ? 1 : 0;
    step_i = 1'b1;
    repeat (10) @(negedge clk_i);
    step_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    // R1: home state
    chk("R1 a_mag", a_mag_o, 22);
    chk("R1 b_mag", b_mag_o, 22);
    chk("R1 signs", {a_sign_o, b_sign_o}, 0);
    chk("R1 rise", {a_rise_o, b_rise_o}, 0);
    chk("R8 drive on", drive_en_o, 1);

    // R2 R6 R7 R9: full sweep forward at finest resolution, with wrap
    set_res(5);
    for (int i = 0; i < 132; i++) do_step(1, "R2 fwd32");
    for (int i = 0; i < 20; i++) do_step(0, "R2 rev32");

    // R3 R4: each coarser resolution both ways
    for (int k = 0; k < 5; k++) begin
      set_res(k);
      for (int i = 0; i < 9; i++) do_step(1, "R3 fwd");
      for (int i = 0; i < 5; i++) do_step(0, "R3 rev");
    end
    set_res(0);
    for (int i = 0; i < 5; i++) begin
      do_step(1, "R4 full");
      chk("R4 full odd", pos % 32, 16);
    end

    // R5: on-the-fly resolution changes from off-grid positions
    set_res(5);
    do_step(1, "R5 prep");
    do_step(1, "R5 prep");
    do_step(1, "R5 prep");
    set_res(2);
    do_step(1, "R5 snap quarter fwd");
    set_res(5);
    do_step(0, "R5 prep");
    set_res(1);
    do_step(0, "R5 snap half rev");
    set_res(5);
    do_step(1, "R5 prep");
    set_res(0);
    do_step(0, "R5 snap full rev");
    set_res(3);
    do_step(1, "R5 snap eighth fwd");
    set_res(0);
    do_step(1, "R5 snap full fwd");

    // R9: decay selection passes through when not rising
    for (int d = 0; d < 8; d++) begin
      @(negedge clk_i);
      decay_sel_i = 3'(d);
      #1 check_all("R9 decay pass");
    end
    decay_sel_i = 3'd5;

    // R8: disable keeps indexer running
    @(negedge clk_i);
    out_dis_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R8 drive off", drive_en_o, 0);
    set_res(4);
    do_step(1, "R8 step while disabled");
    do_step(1, "R8 step while disabled");
    chk("R8 still off", drive_en_o, 0);
    out_dis_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R8 drive back", drive_en_o, 1);

    // R10: short glitches ignored
    for (int g = 1; g <= 2; g++) begin
      @(negedge clk_i);
      step_i = 1'b1;
      repeat (g) @(negedge clk_i);
      step_i = 1'b0;
      repeat (12) @(negedge clk_i);
      check_all("R10 glitch");
    end

    // R11: sleep forces home and ignores steps
    set_res(5);
    do_step(1, "R11 prep");
    @(negedge clk_i);
    sleep_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pos = 16; res = 0; exp_ra = 0; exp_rb = 0;
    chk("R11 drive off", drive_en_o, 0);
    step_i = 1'b1;
    repeat (10) @(negedge clk_i);
    step_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check_all("R11 asleep");
    sleep_i = 1'b0;
    repeat (6) @(negedge clk_i);
    check_all("R11 R1 wake home");
    chk("R11 drive on", drive_en_o, 1);
    set_res(5);
    do_step(1, "R11 resume");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule